// File: doc/BRIEF.md
# Indexed Clock-Enable Generator Bank

The block holds eight programmable generators of clock-enable pulses and a set of peripheral channel selectors, all in one system clock domain. Each generator picks one of several input source strobes. It either passes that strobe through unchanged or divides it, giving one pulse for every N source pulses. Each channel selector routes the pulses of one chosen generator to its peripheral. Every output is a single-cycle enable pulse; no clock is gated.

Configuration goes through an indirect register port. A write to the division register or to the generator control register carries, in the same word, the ID of the generator it targets. A channel write carries the channel number in the same way. A write-protect gate drops bus writes while protection is on. Protection is overridden when the core is halted for debug, when reset is being extended, or when the write comes from an external debugger. Reads return the fields of the generator or channel named by the most recent accepted write to that register.

Each generator is a three-state machine. ST_OFF emits nothing and holds its counter at zero. ST_PASS forwards the selected strobe. ST_DIVIDE counts strobes and emits on the last one of each group. On every clock the next state is worked out from the stored settings with any accepted write applied to them. It is ST_OFF when the enable is clear, ST_PASS when the enable is set and the factor is 0 or 1, and ST_DIVIDE when the enable is set and the factor is 2 or more. The named transitions are as follows. The enable transition ST_OFF to ST_PASS or ST_DIVIDE restarts the count. The retune transition moves between ST_PASS and ST_DIVIDE on a division write. The disable transition goes from any state to ST_OFF.

Top module: `clkgen_bank`

## Requirements
- R1: There are eight generators (IDs 0 to 7). Any channel may select any generator, and several channels may select the same generator.
- R2: A generator that is enabled with a division factor of 0 or 1 drives its gen_pulse bit high in exactly the cycles in which its selected src_pulse bit is high.
- R3: A generator that is enabled with factor N ≥ 2 pulses on the Nth selected source pulse counted from zero, and again on every Nth pulse after that. Its count restarts at zero when it is enabled from off and when its factor is written.
- R4: An accepted write with wr_sel=0 takes the generator ID from bits [2:0] and the factor from bits [15:8]. It changes only the named generator's factor.
- R5: An accepted write with wr_sel=1 takes the ID from bits [2:0], the source index from bits [9:8] and the enable from bit 16. It changes only the named generator. A disabled generator emits no pulses.
- R6: An accepted write with wr_sel=2 takes the channel from bits [3:0], the generator from bits [10:8] and the channel enable from bit 14. Bits 31:16 have no effect, and a channel number of NUM_CHAN or more leaves all state unchanged. chan_pulse[c] is high exactly when channel c is enabled and its selected generator pulses in that cycle. A new selection governs from the next cycle on.
- R7: While prot_en is high and dbg_halt, ext_rst and wr_dbg are all low, writes change no state.
- R8: While dbg_halt or ext_rst is high, writes are accepted whatever prot_en is.
- R9: A write with wr_dbg high is accepted whatever prot_en is.
- R10: rd_sel 0, 1 and 2 return, in the bit positions of R4, R5 and R6, the ID or channel and the fields of the target of the last accepted write of that kind. All other bits read as zero, and rd_sel 3 reads as zero. A write with wr_sel=3 changes nothing.
- R11: After reset all generators are off with factor 0 and source 0, all channels are disabled and select generator 0, and every stored ID is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select: 0 division, 1 generator control, 2 channel, 3 none |
| wr_data | input | 32 | Write word |
| wr_dbg | input | 1 | Write comes from an external debugger |
| prot_en | input | 1 | Write protection active |
| dbg_halt | input | 1 | Core halted for debug |
| ext_rst | input | 1 | Reset extension active |
| src_pulse | input | NUM_SRC | Source strobes |
| rd_sel | input | 2 | Read select, same encoding as wr_sel |
| rd_data | output | 32 | Read-back word |
| gen_pulse | output | NUM_GEN | Generator enable pulses |
| chan_pulse | output | NUM_CHAN | Channel enable pulses |

## Verification
Four checks are made by the assertions on every cycle. A channel pulse is always backed by a pulse of the generator it selects. A generator pulse always coincides with its chosen source strobe. A disabled generator stays silent, and a dividing generator never pulses two cycles in a row. The assertions also check that a blocked write leaves every setting unchanged and that a debugger write lands in the named generator. Other properties need the bench's reference model running through long scenarios: the exact count phase of a divider after a retune or a re-enable, the read-back of the last target, and the effect of ignored fields and out-of-range channels.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

    typedef enum logic [1:0] {
        SEL_DIV  = 2'd0,
        SEL_CTL  = 2'd1,
        SEL_CHAN = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_PASS   = 2'd1,
        ST_DIVIDE = 2'd2
    } gen_state_e;

    // field positions in the write and read words
    localparam int F_ID_LSB   = 0;
    localparam int F_DIV_LSB  = 8;
    localparam int F_SRC_LSB  = 8;
    localparam int F_EN_BIT   = 16;
    localparam int F_CH_LSB   = 0;
    localparam int F_CH_W     = 4;
    localparam int F_CGEN_LSB = 8;
    localparam int F_CEN_BIT  = 14;

endpackage

// File: rtl/clkgen_wgate.sv
module clkgen_wgate (
    input  logic wr_en,
    input  logic wr_dbg,
    input  logic prot_en,
    input  logic dbg_halt,
    input  logic ext_rst,
    output logic wr_ok
);
    logic bypass;

    always_comb begin
        bypass = wr_dbg || dbg_halt || ext_rst;
        wr_ok  = wr_en && (bypass || !prot_en);
    end
endmodule

// File: rtl/clkgen_unit.sv
module clkgen_unit
    import clkgen_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DIV_W   = 8,
    localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_we,
    input  logic [DIV_W-1:0] div_val,
    input  logic             ctl_we,
    input  logic             ctl_en,
    input  logic [SRC_W-1:0] ctl_src,
    input  logic [NUM_SRC-1:0] src_pulse,
    output logic             pulse,
    output logic             on,
    output logic [DIV_W-1:0] div_q,
    output logic [SRC_W-1:0] src_q
);
    gen_state_e       state, state_n;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_n;
    logic             en_n;
    logic             src_hit;
    logic             last_cnt;

    always_comb begin
        en_n  = ctl_we ? ctl_en : (state != ST_OFF);
        div_n = div_we ? div_val : div_q;
        if (!en_n)
            state_n = ST_OFF;
        else if (div_n <= DIV_W'(1))
            state_n = ST_PASS;
        else
            state_n = ST_DIVIDE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_OFF;
        else
            state <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            src_q <= '0;
            cnt   <= '0;
        end else begin
            if (div_we)
                div_q <= div_val;
            if (ctl_we)
                src_q <= ctl_src;
            if (state_n == ST_OFF || state == ST_OFF || div_we)
                cnt <= '0;
            else if (state == ST_DIVIDE && src_hit)
                cnt <= last_cnt ? '0 : cnt + DIV_W'(1);
        end
    end

    // outputs
    always_comb begin
        src_hit  = src_pulse[src_q];
        last_cnt = (cnt == div_q - DIV_W'(1));
        on       = (state != ST_OFF);
        unique case (state)
            ST_OFF:    pulse = 1'b0;
            ST_PASS:   pulse = src_hit;
            ST_DIVIDE: pulse = src_hit && last_cnt;
            default:   pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkgen_chan.sv
module clkgen_chan #(
    parameter int NUM_GEN = 8,
    localparam int GID_W  = $clog2(NUM_GEN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [GID_W-1:0]   sel_val,
    input  logic               en_val,
    input  logic [NUM_GEN-1:0] gen_pulse,
    output logic               pulse,
    output logic [GID_W-1:0]   sel_q,
    output logic               on_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            on_q  <= 1'b0;
        end else if (we) begin
            sel_q <= sel_val;
            on_q  <= en_val;
        end
    end

    assign pulse = on_q && gen_pulse[sel_q];
endmodule

// File: rtl/clkgen_bank.sv
module clkgen_bank
    import clkgen_pkg::*;
#(
    parameter int NUM_GEN  = 8,
    parameter int NUM_SRC  = 4,
    parameter int NUM_CHAN = 6,
    parameter int DIV_W    = 8,
    localparam int GID_W   = $clog2(NUM_GEN),
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [31:0]         wr_data,
    input  logic                wr_dbg,
    input  logic                prot_en,
    input  logic                dbg_halt,
    input  logic                ext_rst,
    input  logic [NUM_SRC-1:0]  src_pulse,
    input  logic [1:0]          rd_sel,
    output logic [31:0]         rd_data,
    output logic [NUM_GEN-1:0]  gen_pulse,
    output logic [NUM_CHAN-1:0] chan_pulse
);
    logic                     wr_ok;
    logic [GID_W-1:0]         wr_id;
    logic [F_CH_W-1:0]        wr_ch;
    logic [NUM_GEN-1:0]       gen_on;
    logic [NUM_GEN*DIV_W-1:0] gen_div_flat;
    logic [NUM_GEN*SRC_W-1:0] gen_src_flat;
    logic [NUM_CHAN*GID_W-1:0] chan_gen_flat;
    logic [NUM_CHAN-1:0]      chan_on;
    logic [GID_W-1:0]         last_div_id, last_ctl_id;
    logic [F_CH_W-1:0]        last_ch;
    logic                     ch_valid;
    logic                     unused_bits;

    assign unused_bits = ^wr_data;
    assign wr_id    = wr_data[F_ID_LSB +: GID_W];
    assign wr_ch    = wr_data[F_CH_LSB +: F_CH_W];
    assign ch_valid = (32'(wr_ch) < NUM_CHAN);

    clkgen_wgate u_gate (
        .wr_en    (wr_en),
        .wr_dbg   (wr_dbg),
        .prot_en  (prot_en),
        .dbg_halt (dbg_halt),
        .ext_rst  (ext_rst),
        .wr_ok    (wr_ok)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        clkgen_unit #(.NUM_SRC(NUM_SRC), .DIV_W(DIV_W)) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .div_we    (wr_ok && wr_sel == SEL_DIV && wr_id == GID_W'(g)),
            .div_val   (wr_data[F_DIV_LSB +: DIV_W]),
            .ctl_we    (wr_ok && wr_sel == SEL_CTL && wr_id == GID_W'(g)),
            .ctl_en    (wr_data[F_EN_BIT]),
            .ctl_src   (wr_data[F_SRC_LSB +: SRC_W]),
            .src_pulse (src_pulse),
            .pulse     (gen_pulse[g]),
            .on        (gen_on[g]),
            .div_q     (gen_div_flat[g*DIV_W +: DIV_W]),
            .src_q     (gen_src_flat[g*SRC_W +: SRC_W])
        );
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        clkgen_chan #(.NUM_GEN(NUM_GEN)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (wr_ok && wr_sel == SEL_CHAN && wr_ch == F_CH_W'(c)),
            .sel_val   (wr_data[F_CGEN_LSB +: GID_W]),
            .en_val    (wr_data[F_CEN_BIT]),
            .gen_pulse (gen_pulse),
            .pulse     (chan_pulse[c]),
            .sel_q     (chan_gen_flat[c*GID_W +: GID_W]),
            .on_q      (chan_on[c])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_div_id <= '0;
            last_ctl_id <= '0;
            last_ch     <= '0;
        end else if (wr_ok) begin
            if (wr_sel == SEL_DIV)
                last_div_id <= wr_id;
            if (wr_sel == SEL_CTL)
                last_ctl_id <= wr_id;
            if (wr_sel == SEL_CHAN && ch_valid)
                last_ch <= wr_ch;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_sel)
            SEL_DIV: begin
                rd_data[F_ID_LSB +: GID_W]  = last_div_id;
                rd_data[F_DIV_LSB +: DIV_W] = gen_div_flat[last_div_id*DIV_W +: DIV_W];
            end
            SEL_CTL: begin
                rd_data[F_ID_LSB +: GID_W]  = last_ctl_id;
                rd_data[F_SRC_LSB +: SRC_W] = gen_src_flat[last_ctl_id*SRC_W +: SRC_W];
                rd_data[F_EN_BIT]           = gen_on[last_ctl_id];
            end
            SEL_CHAN: begin
                rd_data[F_CH_LSB +: F_CH_W]  = last_ch;
                rd_data[F_CGEN_LSB +: GID_W] = chan_gen_flat[32'(last_ch)*GID_W +: GID_W];
                rd_data[F_CEN_BIT]           = chan_on[last_ch];
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/clkgen_bank_chk.sv
module clkgen_bank_chk
    import clkgen_pkg::*;
#(
    parameter int NUM_GEN  = 8,
    parameter int NUM_SRC  = 4,
    parameter int NUM_CHAN = 6,
    parameter int DIV_W    = 8,
    localparam int GID_W   = $clog2(NUM_GEN),
    localparam int SRC_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [1:0]                wr_sel,
    input logic [31:0]               wr_data,
    input logic                      wr_dbg,
    input logic                      prot_en,
    input logic                      dbg_halt,
    input logic                      ext_rst,
    input logic [NUM_SRC-1:0]        src_pulse,
    input logic [NUM_GEN-1:0]        gen_pulse,
    input logic [NUM_CHAN-1:0]       chan_pulse,
    input logic [NUM_GEN-1:0]        gen_on,
    input logic [NUM_GEN*SRC_W-1:0]  gen_src_flat,
    input logic [NUM_GEN*DIV_W-1:0]  gen_div_flat,
    input logic [NUM_CHAN*GID_W-1:0] chan_gen_flat,
    input logic [NUM_CHAN-1:0]       chan_on
);
    AST_PROT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && prot_en && !dbg_halt && !ext_rst && !wr_dbg |=>
        $stable(gen_div_flat) && $stable(gen_src_flat) && $stable(gen_on) &&
        $stable(chan_gen_flat) && $stable(chan_on)); // R7

    AST_DBG_DIV_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_dbg && wr_sel == SEL_DIV |=>
        gen_div_flat[$past(wr_data[F_ID_LSB +: GID_W])*DIV_W +: DIV_W] ==
        $past(wr_data[F_DIV_LSB +: DIV_W])); // R9

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gchk
        AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_on[g] |-> !gen_pulse[g]); // R5

        AST_SRC_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
            gen_pulse[g] |-> src_pulse[gen_src_flat[g*SRC_W +: SRC_W]]); // R2

        AST_DIV_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            gen_pulse[g] && !wr_en && gen_div_flat[g*DIV_W +: DIV_W] >= DIV_W'(2) |=>
            !gen_pulse[g]); // R3
    end

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_cchk
        AST_CHAN_BACKED: assert property (@(posedge clk) disable iff (!rst_n)
            chan_pulse[c] |-> chan_on[c] && gen_pulse[chan_gen_flat[c*GID_W +: GID_W]]); // R6
    end
endmodule

bind clkgen_bank clkgen_bank_chk #(
    .NUM_GEN  (NUM_GEN),
    .NUM_SRC  (NUM_SRC),
    .NUM_CHAN (NUM_CHAN),
    .DIV_W    (DIV_W)
) u_chk (.*);

// File: tb/test_clkgen_bank.sv
module test_clkgen_bank;
    localparam int NG = 8;
    localparam int NS = 4;
    localparam int NC = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_dbg, prot_en, dbg_halt, ext_rst;
    logic [1:0]  wr_sel, rd_sel;
    logic [31:0] wr_data, rd_data;
    logic [NS-1:0] src_pulse;
    logic [NG-1:0] gen_pulse;
    logic [NC-1:0] chan_pulse;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state
    int m_div[NG];
    int m_src[NG];
    int m_cnt[NG];
    bit m_en[NG];
    int m_cg[NC];
    bit m_ce[NC];
    int m_ldiv, m_lctl, m_lch;

    always #2 clk = ~clk;

    clkgen_bank i_clkgen_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_dbg(wr_dbg), .prot_en(prot_en), .dbg_halt(dbg_halt), .ext_rst(ext_rst),
        .src_pulse(src_pulse), .rd_sel(rd_sel), .rd_data(rd_data),
        .gen_pulse(gen_pulse), .chan_pulse(chan_pulse)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int g = 0; g < NG; g++) begin
            m_div[g] = 0; m_src[g] = 0; m_cnt[g] = 0; m_en[g] = 0;
        end
        for (int c = 0; c < NC; c++) begin
            m_cg[c] = 0; m_ce[c] = 0;
        end
        m_ldiv = 0; m_lctl = 0; m_lch = 0;
    endtask

    function automatic bit exp_gen(int g);
        if (!m_en[g] || !src_pulse[m_src[g]]) return 0;
        if (m_div[g] <= 1) return 1;
        return m_cnt[g] == m_div[g] - 1;
    endfunction

    task automatic compare(string tag);
        logic [NG-1:0] eg;
        logic [NC-1:0] ec;
        logic [31:0]   er;
        for (int g = 0; g < NG; g++) eg[g] = exp_gen(g);
        for (int c = 0; c < NC; c++) ec[c] = m_ce[c] && eg[m_cg[c]];
        er = 0;
        case (rd_sel)
            2'd0: er = m_ldiv | (m_div[m_ldiv] << 8);
            2'd1: er = m_lctl | (m_src[m_lctl] << 8) | (int'(m_en[m_lctl]) << 16);
            2'd2: er = m_lch | (m_cg[m_lch] << 8) | (int'(m_ce[m_lch]) << 14);
            default: er = 0;
        endcase
        chk({tag, " gen_pulse R2 R3 R4 R5 R7 R8 R9"}, 32'(gen_pulse), 32'(eg));
        chk({tag, " chan_pulse R1 R6"}, 32'(chan_pulse), 32'(ec));
        chk({tag, " rd_data R10"}, rd_data, er);
    endtask

    task automatic model_step();
        bit ok;
        int id, ch, nen[NG], ncnt[NG];
        bit dw[NG], cw[NG];
        ok = wr_en && (wr_dbg || !prot_en || dbg_halt || ext_rst);
        id = int'(wr_data[2:0]);
        ch = int'(wr_data[3:0]);
        for (int g = 0; g < NG; g++) begin
            dw[g] = ok && wr_sel == 2'd0 && id == g;
            cw[g] = ok && wr_sel == 2'd1 && id == g;
            nen[g] = cw[g] ? int'(wr_data[16]) : int'(m_en[g]);
            ncnt[g] = m_cnt[g];
            if (nen[g] == 0 || !m_en[g] || dw[g])
                ncnt[g] = 0;
            else if (m_div[g] >= 2 && src_pulse[m_src[g]])
                ncnt[g] = (m_cnt[g] == m_div[g] - 1) ? 0 : m_cnt[g] + 1;
        end
        for (int g = 0; g < NG; g++) begin
            m_cnt[g] = ncnt[g];
            m_en[g]  = nen[g] != 0;
            if (dw[g]) m_div[g] = int'(wr_data[15:8]);
            if (cw[g]) m_src[g] = int'(wr_data[9:8]);
        end
        if (ok && wr_sel == 2'd0) m_ldiv = id;
        if (ok && wr_sel == 2'd1) m_lctl = id;
        if (ok && wr_sel == 2'd2 && ch < NC) begin
            m_cg[ch] = int'(wr_data[10:8]);
            m_ce[ch] = wr_data[14];
            m_lch    = ch;
        end
    endtask

    // inputs set at negedge; compare 1 ns later; model follows the edge
    task automatic step(string tag);
        #1;
        compare(tag);
        if (rst_n) model_step(); else model_reset();
        @(posedge clk);
        @(negedge clk);
        rd_sel = rd_sel + 2'd1;
    endtask

    task automatic idle(int n, int density);
        for (int i = 0; i < n; i++) begin
            for (int s = 0; s < NS; s++) src_pulse[s] = ($urandom % 100) < density;
            step("idle");
        end
    endtask

    task automatic wr(logic [1:0] sel, logic [31:0] data, logic dbg, string tag);
        wr_en = 1'b1; wr_sel = sel; wr_data = data; wr_dbg = dbg;
        src_pulse = NS'($urandom);
        step(tag);
        wr_en = 1'b0; wr_dbg = 1'b0; wr_data = '0;
    endtask

    function automatic logic [31:0] dw_(int id, int div);
        return 32'(id) | (32'(div) << 8);
    endfunction
    function automatic logic [31:0] cw_(int id, int src, bit en);
        return 32'(id) | (32'(src) << 8) | (32'(en) << 16);
    endfunction
    function automatic logic [31:0] chw_(int ch, int gen, bit en);
        return 32'(ch) | (32'(gen) << 8) | (32'(en) << 14);
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_sel = 0; wr_data = 0; wr_dbg = 0;
        prot_en = 0; dbg_halt = 0; ext_rst = 0; src_pulse = 0; rd_sel = 0;
        model_reset();
        @(negedge clk);
        for (int i = 0; i < 4; i++) step("reset R11");
        rst_n = 1;
        src_pulse = '1;
        for (int i = 0; i < 4; i++) step("after reset R11");

        wr(2'd0, dw_(0, 0), 0, "div g0 R4");
        wr(2'd1, cw_(0, 0, 1), 0, "en g0 R5");
        wr(2'd0, dw_(1, 3), 0, "div g1 R4");
        wr(2'd1, cw_(1, 1, 1), 0, "en g1 R5");
        wr(2'd0, dw_(2, 2), 0, "div g2");
        wr(2'd1, cw_(2, 0, 1), 0, "en g2");
        wr(2'd0, dw_(5, 1), 0, "div g5");
        wr(2'd1, cw_(5, 3, 1), 0, "en g5");
        wr(2'd1, cw_(7, 2, 1), 0, "en g7");
        wr(2'd2, chw_(0, 1, 1), 0, "ch0 R6");
        wr(2'd2, chw_(1, 2, 1), 0, "ch1 R1");
        wr(2'd2, chw_(2, 0, 1), 0, "ch2");
        wr(2'd2, chw_(3, 5, 1), 0, "ch3");
        wr(2'd2, chw_(4, 3, 1), 0, "ch4 disabled gen");
        wr(2'd2, chw_(5, 1, 1), 0, "ch5 shares g1 R1");
        idle(200, 50);
        idle(40, 100);
        wr(2'd0, dw_(1, 5), 0, "retune g1 R3");
        idle(100, 60);
        wr(2'd1, cw_(2, 0, 0), 0, "disable g2 R5");
        idle(40, 80);
        wr(2'd1, cw_(2, 0, 1), 0, "reenable g2 R3");
        idle(40, 80);
        wr(2'd2, chw_(0, 2, 1), 0, "reselect ch0 R6");
        idle(40, 70);
        wr(2'd2, 32'hFFFF_0000 | chw_(3, 5, 1), 0, "upper bits ignored R6");
        wr(2'd2, chw_(9, 4, 0), 0, "bad channel R6");
        wr(2'd3, 32'hFFFF_FFFF, 0, "no-op select R10");
        idle(20, 70);

        prot_en = 1;
        wr(2'd0, dw_(0, 4), 0, "blocked div R7");
        wr(2'd1, cw_(1, 1, 0), 0, "blocked ctl R7");
        wr(2'd2, chw_(2, 7, 0), 0, "blocked chan R7");
        idle(30, 70);
        wr(2'd0, dw_(0, 4), 1, "debugger div R9");
        idle(30, 70);
        dbg_halt = 1;
        wr(2'd1, cw_(1, 1, 0), 0, "halt ctl R8");
        dbg_halt = 0;
        ext_rst = 1;
        wr(2'd2, chw_(1, 0, 1), 0, "ext reset chan R8");
        ext_rst = 0;
        idle(40, 70);

        for (int i = 0; i < 800; i++) begin
            prot_en  = ($urandom % 3) == 0;
            dbg_halt = ($urandom % 8) == 0;
            ext_rst  = ($urandom % 8) == 0;
            if (($urandom % 4) == 0) begin
                case ($urandom % 3)
                    0: wr(2'd0, dw_($urandom % 8, $urandom % 6), ($urandom % 4) == 0, "rand div");
                    1: wr(2'd1, cw_($urandom % 8, $urandom % 4, ($urandom % 4) != 0), ($urandom % 4) == 0, "rand ctl");
                    default: wr(2'd2, chw_($urandom % 8, $urandom % 8, ($urandom % 4) != 0), ($urandom % 4) == 0, "rand chan");
                endcase
            end else begin
                idle(1, 60);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule